// File: doc/BRIEF.md
# SAR ADC Serial Frame Controller

This block is the digital control side of a 14-bit successive-approximation converter with an SPI-style serial port. A host frames each transaction with an active-low chip select and clocks it with a serial clock. The block counts serial-clock falling edges inside the frame. From that count it finishes a conversion, starts an offset calibration, or treats the frame as short. While the frame runs, it shifts the result of the previous conversion out on a serial data line.

Chip select and serial clock are sampled on a free-running system clock, and every edge is detected in that domain. A parallel result bus stands in for the analog core and is latched when a conversion completes. Calibration reaches the core as a single-cycle pulse. An acquisition timer, also on the system clock, reports a frame that begins before the programmed minimum acquisition time has passed.

Top module: `sarfc_top`

## Requirements
- R1: After reset the state is acquisition (code 0), the serial output enable is low, and the invalid flag, conversion-done pulse, calibration pulse and early-frame error are all low.
- R2: The serial output is released (enable low) whenever chip select is high. On the system clock after chip select falls, the output is enabled and drives 0.
- R3: The serial output carries the previous result MSB first. The first bit appears on the serial-clock rising edge after the first falling edge of the frame, and one further bit appears on each later rising edge.
- R4: Once all 14 result bits have gone out, every further rising edge in the frame drives 0.
- R5: On the 18th falling edge of a frame the result bus is latched, a one-cycle conversion-done pulse is raised and the state returns to acquisition (code 0). Before that edge the state is conversion (code 1).
- R6: A frame that ends with fewer than 18 falling edges sets the invalid flag. The flag stays set until the 18th falling edge of a later frame.
- R7: The first frame after reset shifts out all zeros.
- R8: In the first frame after reset, the 24th falling edge raises a one-cycle calibration pulse and puts the state in calibration (code 2).
- R9: In any later frame, calibration starts on the 64th falling edge instead. A 24-edge frame does not calibrate.
- R10: If chip select rises before the calibration edge count of that frame is reached, no calibration pulse is produced.
- R11: Chip select rising returns the state to acquisition from any state.
- R12: The acquisition counter restarts when a conversion completes, and when chip select rises outside acquisition. A chip select fall that is registered with the counter below the minimum input raises a one-cycle early-frame error.
- R13: A frame produces at most one calibration pulse, however many edges follow the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, synchronous to clk |
| sclk | input | 1 | Serial clock, idle high, synchronous to clk |
| conv_data | input | 14 | Result presented by the converter core |
| acq_min | input | 8 | Minimum acquisition time in system-clock cycles |
| sdo | output | 1 | Serial data, high impedance when not enabled |
| sdo_oe | output | 1 | Serial data enable |
| state_o | output | 2 | 0 acquisition, 1 conversion, 2 calibration |
| conv_done | output | 1 | One-cycle pulse when a conversion completes |
| cal_pulse | output | 1 | One-cycle pulse starting offset calibration |
| result_invalid | output | 1 | Result now being shifted out is not trustworthy |
| acq_early_err | output | 1 | One-cycle pulse for a frame started too early |

## Verification
The properties assume that chip select and the serial clock are already synchronous to the system clock and hold each level for at least one cycle. They also assume the serial clock is high whenever chip select changes, so that no serial edge shares a cycle with a frame edge. The stimulus changes inputs only on falling system-clock edges and holds each serial-clock phase for one or two cycles. Frame lengths are drawn from the short, converting, first-frame-calibrating and run-time-calibrating ranges, and the gaps between frames straddle the minimum acquisition time.

// File: rtl/sarfc_pkg.sv
package sarfc_pkg;

  typedef enum logic [1:0] {
    ST_ACQ = 2'd0,
    ST_CNV = 2'd1,
    ST_CAL = 2'd2
  } conv_state_e;

  // falling-edge count that starts calibration in the current frame
  function automatic int calib_edges(input bit first_frame, input int pwrup_edges,
                                     input int run_edges);
    return first_frame ? pwrup_edges : run_edges;
  endfunction

  // word that leaves on the serial line in a frame
  function automatic logic [31:0] frame_word(input bit first_frame, input logic [31:0] last_res);
    return first_frame ? 32'd0 : last_res;
  endfunction

endpackage

// File: rtl/sarfc_edges.sv
module sarfc_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  output logic cs_fall,
  output logic cs_rise,
  output logic sclk_fall,
  output logic sclk_rise
);
  logic cs_q;
  logic sclk_q;
  logic frame_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end
  end

  // serial edges count only when select was low last cycle and still is
  assign frame_act = ~cs_q & ~cs_n;
  assign cs_fall   = cs_q & ~cs_n;
  assign cs_rise   = ~cs_q & cs_n;
  assign sclk_fall = frame_act & sclk_q & ~sclk;
  assign sclk_rise = frame_act & ~sclk_q & sclk;
endmodule

// File: rtl/sarfc_frame_ctrl.sv
module sarfc_frame_ctrl #(
  parameter int RES_W      = 14,
  parameter int CONV_EDGES = 18,
  parameter int CAL_PWRUP  = 24,
  parameter int CAL_RUN    = 64,
  parameter int CNT_W      = $clog2(CAL_RUN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_fall,
  input  logic                   cs_rise,
  input  logic                   sclk_fall,
  input  logic [RES_W-1:0]       conv_data,
  output sarfc_pkg::conv_state_e state,
  output logic [CNT_W-1:0]       fall_cnt,
  output logic [RES_W-1:0]       res_q,
  output logic [RES_W-1:0]       out_word,
  output logic                   first_q,
  output logic                   invalid_q,
  output logic                   conv_done,
  output logic                   cal_pulse,
  output logic                   conv_event,
  output logic                   acq_restart
);
  import sarfc_pkg::*;

  localparam logic [CNT_W-1:0] CONV_L = CNT_W'(CONV_EDGES);
  localparam logic [CNT_W-1:0] SAT_L  = CNT_W'(CAL_RUN);

  logic [CNT_W-1:0] fall_nxt;
  logic [CNT_W-1:0] cal_lim;
  logic             count_ev;
  logic             cal_event;
  logic [31:0]      word_sel;

  assign cal_lim    = CNT_W'(calib_edges(first_q, CAL_PWRUP, CAL_RUN));
  assign count_ev   = sclk_fall && (fall_cnt != SAT_L);
  assign fall_nxt   = fall_cnt + 1'b1;
  assign conv_event = count_ev && (fall_nxt == CONV_L);
  assign cal_event  = count_ev && (fall_nxt == cal_lim);
  assign acq_restart = conv_event || (cs_rise && (state != ST_ACQ));
  assign word_sel   = frame_word(first_q, 32'(res_q));
  assign out_word   = word_sel[RES_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_ACQ;
      fall_cnt  <= '0;
      res_q     <= '0;
      first_q   <= 1'b1;
      invalid_q <= 1'b0;
      conv_done <= 1'b0;
      cal_pulse <= 1'b0;
    end else begin
      conv_done <= 1'b0;
      cal_pulse <= 1'b0;
      if (cs_fall) begin
        state    <= ST_CNV;
        fall_cnt <= '0;
      end else if (cs_rise) begin
        state   <= ST_ACQ;
        first_q <= 1'b0;
        if (fall_cnt < CONV_L) invalid_q <= 1'b1;
      end else if (count_ev) begin
        fall_cnt <= fall_nxt;
        if (conv_event) begin
          res_q     <= conv_data;
          state     <= ST_ACQ;
          invalid_q <= 1'b0;
          conv_done <= 1'b1;
        end
        if (cal_event) begin
          state     <= ST_CAL;
          cal_pulse <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sarfc_sdo_shift.sv
module sarfc_sdo_shift #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             shift_en,
  input  logic [RES_W-1:0] load_word,
  output logic             sdo_d,
  output logic             sdo_oe
);
  logic [RES_W-1:0] sh_q;

  // zeros enter from the bottom, so the tail of any frame is 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      sdo_d  <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (cs_fall) begin
      sh_q   <= load_word;
      sdo_d  <= 1'b0;
      sdo_oe <= 1'b1;
    end else if (cs_rise) begin
      sdo_d  <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (shift_en) begin
      sdo_d <= sh_q[RES_W-1];
      sh_q  <= {sh_q[RES_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sarfc_acq_timer.sv
module sarfc_acq_timer #(
  parameter int ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cs_fall,
  input  logic [ACQ_W-1:0] acq_min,
  output logic             early_err
);
  localparam logic [ACQ_W-1:0] CNT_MAX = '1;

  logic [ACQ_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      early_err <= 1'b0;
    end else begin
      early_err <= cs_fall && (cnt_q < acq_min);
      if (restart)               cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sarfc_top.sv
module sarfc_top #(
  parameter int RES_W      = 14,
  parameter int CONV_EDGES = 18,
  parameter int CAL_PWRUP  = 24,
  parameter int CAL_RUN    = 64,
  parameter int ACQ_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] conv_data,
  input  logic [ACQ_W-1:0] acq_min,
  output wire              sdo,
  output logic             sdo_oe,
  output logic [1:0]       state_o,
  output logic             conv_done,
  output logic             cal_pulse,
  output logic             result_invalid,
  output logic             acq_early_err
);
  localparam int CNT_W = $clog2(CAL_RUN + 1);

  logic                  cs_fall_w;
  logic                  cs_rise_w;
  logic                  sclk_fall_w;
  logic                  sclk_rise_w;
  logic                  shift_en_w;
  logic                  conv_event_w;
  logic                  acq_restart_w;
  logic                  first_w;
  logic                  sdo_d_w;
  logic [CNT_W-1:0]      fall_cnt_w;
  logic [RES_W-1:0]      res_w;
  logic [RES_W-1:0]      out_word_w;
  sarfc_pkg::conv_state_e state_w;

  sarfc_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .cs_fall  (cs_fall_w),
    .cs_rise  (cs_rise_w),
    .sclk_fall(sclk_fall_w),
    .sclk_rise(sclk_rise_w)
  );

  sarfc_frame_ctrl #(
    .RES_W     (RES_W),
    .CONV_EDGES(CONV_EDGES),
    .CAL_PWRUP (CAL_PWRUP),
    .CAL_RUN   (CAL_RUN),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (cs_fall_w),
    .cs_rise    (cs_rise_w),
    .sclk_fall  (sclk_fall_w),
    .conv_data  (conv_data),
    .state      (state_w),
    .fall_cnt   (fall_cnt_w),
    .res_q      (res_w),
    .out_word   (out_word_w),
    .first_q    (first_w),
    .invalid_q  (result_invalid),
    .conv_done  (conv_done),
    .cal_pulse  (cal_pulse),
    .conv_event (conv_event_w),
    .acq_restart(acq_restart_w)
  );

  // bits move only on rising edges that follow a falling edge of this frame
  assign shift_en_w = sclk_rise_w && (fall_cnt_w != '0);

  sarfc_sdo_shift #(.RES_W(RES_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_fall  (cs_fall_w),
    .cs_rise  (cs_rise_w),
    .shift_en (shift_en_w),
    .load_word(out_word_w),
    .sdo_d    (sdo_d_w),
    .sdo_oe   (sdo_oe)
  );

  sarfc_acq_timer #(.ACQ_W(ACQ_W)) u_acq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (acq_restart_w),
    .cs_fall  (cs_fall_w),
    .acq_min  (acq_min),
    .early_err(acq_early_err)
  );

  assign state_o = state_w;
  assign sdo     = sdo_oe ? sdo_d_w : 1'bz;
endmodule

// File: rtl/sarfc_checker.sv
module sarfc_checker #(
  parameter int RES_W      = 14,
  parameter int CONV_EDGES = 18,
  parameter int CNT_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_fall_w,
  input logic             cs_rise_w,
  input logic             shift_en_w,
  input logic             first_w,
  input logic             sdo_d_w,
  input logic             sdo_oe,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] fall_cnt_w,
  input logic [RES_W-1:0] res_w,
  input logic [RES_W-1:0] conv_data,
  input logic             conv_done,
  input logic             cal_pulse,
  input logic             result_invalid,
  input logic             acq_early_err
);
  import sarfc_pkg::*;

  assert_sdo_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_w |=> !sdo_oe);

  assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_w |=> (sdo_oe && !sdo_d_w));

  assert_first_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_w && first_w) |=> !sdo_d_w);

  assert_conv_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (state_o == ST_ACQ && res_w == $past(conv_data)));

  assert_invalid_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_w && fall_cnt_w < CNT_W'(CONV_EDGES)) |=> result_invalid);

  assert_invalid_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> !result_invalid);

  assert_cal_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |-> (state_o == ST_CAL));

  assert_cal_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cal_pulse |=> !cal_pulse);

  assert_back_to_acq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_w |=> (state_o == ST_ACQ));

  assert_err_at_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acq_early_err |-> $past(cs_fall_w));

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

bind sarfc_top sarfc_checker #(
  .RES_W     (RES_W),
  .CONV_EDGES(CONV_EDGES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_fall_w     (cs_fall_w),
  .cs_rise_w     (cs_rise_w),
  .shift_en_w    (shift_en_w),
  .first_w       (first_w),
  .sdo_d_w       (sdo_d_w),
  .sdo_oe        (sdo_oe),
  .state_o       (state_o),
  .fall_cnt_w    (fall_cnt_w),
  .res_w         (res_w),
  .conv_data     (conv_data),
  .conv_done     (conv_done),
  .cal_pulse     (cal_pulse),
  .result_invalid(result_invalid),
  .acq_early_err (acq_early_err)
);

// File: tb/tb_sarfc_top.sv
`timescale 1ns/1ps
module tb_sarfc_top;
  localparam int RW = 14;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sclk = 1'b1;
  logic [RW-1:0] conv_data = '0;
  logic [AW-1:0] acq_min = 8'd6;
  wire           sdo;
  logic          sdo_oe;
  logic [1:0]    state_o;
  logic          conv_done, cal_pulse, result_invalid, acq_early_err;

  sarfc_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .conv_data(conv_data),
    .acq_min(acq_min), .sdo(sdo), .sdo_oe(sdo_oe), .state_o(state_o),
    .conv_done(conv_done), .cal_pulse(cal_pulse), .result_invalid(result_invalid),
    .acq_early_err(acq_early_err)
  );

  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  int ncal     = 0;
  int ndone    = 0;
  int nerr_p   = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cal_pulse)     ncal   <= ncal + 1;
    if (conv_done)     ndone  <= ndone + 1;
    if (acq_early_err) nerr_p <= nerr_p + 1;
  end

  // reference model state
  bit          first_m = 1;
  bit          inv_m   = 0;
  logic [RW-1:0] res_m = '0;
  int          mark    = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int cal_edges_ref(input bit first);
    if (first) return 24;
    return 64;
  endfunction

  function automatic int state_ref(input int nfall, input int thr);
    if (nfall >= thr) return 2;
    if (nfall >= 18)  return 0;
    return 1;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mark = cyc - 1;
    first_m = 1; inv_m = 0; res_m = '0;
    @(negedge clk);
    chk("R1", "state", int'(state_o), 0);
    chk("R1", "sdo_oe", int'(sdo_oe), 0);
    chk("R1", "invalid", int'(result_invalid), 0);
    chk("R1", "pulses", int'({conv_done, cal_pulse, acq_early_err}), 0);
  endtask

  task automatic run_frame(input int nfall, input logic [RW-1:0] d, input int gap);
    logic [RW-1:0] expw, got;
    bit  tail, exp_err;
    int  thr, st_exp, mark18, h, c_cal, c_done, c_err, sh;
    repeat (gap) @(negedge clk);
    expw = first_m ? '0 : res_m;
    thr  = cal_edges_ref(first_m);
    chk("R6", "invalid at frame start", int'(result_invalid), int'(inv_m));
    exp_err = (cyc - mark) <= int'(acq_min);
    c_cal = ncal; c_done = ndone; c_err = nerr_p;
    got = '0; tail = 0; mark18 = 0;
    cs_n = 1'b0; sclk = 1'b1; conv_data = d;
    @(negedge clk);
    chk("R2", "enable after select", int'(sdo_oe), 1);
    chk("R2", "leading zero", int'(sdo), 0);
    for (int i = 1; i <= nfall; i++) begin
      h = $urandom_range(1, 2);
      sclk = 1'b0;
      if (i == 18) mark18 = cyc;
      repeat (h) @(negedge clk);
      sclk = 1'b1;
      repeat (h) @(negedge clk);
      if (i <= RW) got[RW-i] = sdo;
      else if (sdo !== 1'b0) tail = 1;
    end
    if (nfall > 0) begin
      sh = (nfall >= RW) ? 0 : RW - nfall;
      chk(first_m ? "R7" : "R3", "shifted word", int'(got >> sh), int'(expw >> sh));
    end
    if (nfall > RW) chk("R4", "tail zeros", int'(tail), 0);
    st_exp = state_ref(nfall, thr);
    chk("R5", "state before deselect", int'(state_o), st_exp);
    chk(nfall > thr ? "R13" : (first_m ? "R8 R10" : "R9 R10"), "calibration pulses",
        ncal - c_cal, (nfall >= thr) ? 1 : 0);
    chk("R5", "conversion pulses", ndone - c_done, (nfall >= 18) ? 1 : 0);
    chk("R12", "early errors", nerr_p - c_err, exp_err ? 1 : 0);
    cs_n = 1'b1;
    mark = (st_exp != 0) ? cyc : mark18;
    @(negedge clk);
    chk("R11", "state after deselect", int'(state_o), 0);
    chk("R2", "released", int'(sdo_oe), 0);
    if (nfall >= 18) begin res_m = d; inv_m = 0; end
    else inv_m = 1;
    first_m = 0;
    chk("R6", "invalid after deselect", int'(result_invalid), int'(inv_m));
  endtask

  initial begin
    int r, nf;
    void'($urandom(32'd4242));
    do_reset();
    run_frame(24, 14'h1234, 20);   // power-up calibration, zeros out
    run_frame(18, 14'h2AAA, 10);   // shows 1234
    run_frame(24, 14'h0F0F, 10);   // no calibration after first frame
    run_frame(64, 14'h3FFF, 10);   // run-time calibration
    run_frame(70, 14'h0001, 10);   // single pulse past threshold
    run_frame(10, 14'h1111, 10);   // short frame
    run_frame(20, 14'h2222, 10);   // invalid, then cleared
    run_frame(40, 14'h3333, 10);   // aborted calibration
    run_frame(5,  14'h0444, 10);
    run_frame(5,  14'h0555, 5);    // boundary: one cycle too early
    run_frame(0,  14'h0666, 6);    // boundary: just enough
    do_reset();
    run_frame(20, 14'h0777, 20);   // first frame aborted before 24
    run_frame(24, 14'h0888, 10);   // no longer first frame
    for (int k = 0; k < 40; k++) begin
      r = $urandom_range(0, 3);
      case (r)
        0: nf = $urandom_range(0, 17);
        1: nf = $urandom_range(18, 23);
        2: nf = $urandom_range(24, 63);
        default: nf = $urandom_range(64, 70);
      endcase
      run_frame(nf, 14'($urandom), $urandom_range(1, 10));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule